// File: doc/BRIEF.md
# VGA Framebuffer Scan-Out

The block generates a 640x480 raster from a 25 MHz pixel clock and streams the picture out of a 320x240 framebuffer whose pixels are 16 bits wide. Each stored pixel covers a 2x2 square on screen. While the beam is inside the visible window, the block computes a byte address for the framebuffer. The memory returns data on the next clock edge. The block widens that 16-bit value to 30-bit RGB and drives it with both sync signals and a blank flag.

Two address layouts are available, chosen by a static input. The first is a linear row-major index. The second packs the row number above the column number. In both layouts the pixel index is shifted left so that it becomes a byte address for the pixel width. All raster counts are parameters, so a reduced raster can be built for test.

Top module: `vga_scanout`

## Requirements
- R1: Each line is 800 clocks long and runs in this order: hsync_n low for 96 clocks, 48 back-porch clocks, 640 visible clocks, then 16 front-porch clocks.
- R2: Each frame is 525 lines long. vsync_n is low during lines 0 and 1, and lines 35 to 514 carry picture.
- R3: blank is high on every clock outside the visible window (columns 144..783 of lines 35..514 of the raster count). While blank is high, rgb is all zeros.
- R4: Screen column c and line l of the visible window read stored pixel (c/2, l/2), so every stored pixel is shown as a 2x2 square.
- R5: With xy_mode=0, rd_addr = (py*320 + px)*2, where px and py are the stored pixel column and row.
- R6: With xy_mode=1, rd_addr = {py[7:0], px[8:0]} shifted left by one bit.
- R7: rd_addr is zero on every clock outside the visible window.
- R8: rgb = {R10, G10, B10}. R is rd_data[15:11], G is rd_data[10:5] and B is rd_data[4:0]. Each channel is widened to 10 bits by repeating its top bits below itself.
- R9: The address for a raster position is presented on one clock. rd_data is taken one clock later. hsync_n, vsync_n, blank and rgb for that position all appear together two clocks after the address.
- R10: While rst is high, hsync_n=1, vsync_n=1, blank=1, rgb=0 and rd_addr=0. After reset is released the raster starts again at the first clock of line 0.
- R11: After the last clock of the last line, the raster wraps to line 0 and starts the next frame with a vertical sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| xy_mode | input | 1 | Address layout: 0 linear, 1 row/column packed |
| rd_addr | output | 18 | Framebuffer byte address |
| rd_data | input | 16 | Pixel returned one clock after rd_addr |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | High outside the visible window |
| rgb | output | 30 | Colour, 10 bits per channel, red in the top bits |

## Verification
The hardest condition to reach is the end of a frame. At full size a frame lasts 420,000 clocks, so the wrap back into vertical sync cannot be reached within the run length. The bench therefore runs a second copy built with a tiny raster next to the full-size one, and checks that copy across several frame wraps. On the full-size copy, the two address layouts agree on the first stored row. The runs therefore continue into later lines, where the row term is nonzero and the layouts separate.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;

    typedef struct packed {
        logic hs_n;
        logic vs_n;
        logic act;
    } vid_ctl_t;

    localparam vid_ctl_t CTL_IDLE = '{hs_n: 1'b1, vs_n: 1'b1, act: 1'b0};

    // Widest of the two address layouts, plus the byte shift for the pixel width.
    function automatic int scan_addr_w(input int h_act, input int v_act, input int pix_bits);
        int fw;
        int fh;
        int iw;
        int xy;
        fw = h_act / 2;
        fh = v_act / 2;
        iw = $clog2(fw * fh);
        xy = $clog2(fw) + $clog2(fh);
        return ((iw > xy) ? iw : xy) + $clog2(pix_bits / 8);
    endfunction

    // Widen 5-6-5 colour to 10 bits per channel by repeating the top bits.
    function automatic logic [29:0] expand565(input logic [15:0] p);
        return {p[15:11], p[15:11], p[10:5], p[10:7], p[4:0], p[4:0]};
    endfunction

endpackage

// File: rtl/vga_timing.sv
module vga_timing
    import vga_scan_pkg::*;
#(
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int H_ACT  = 640,
    parameter int H_FP   = 16,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 33,
    parameter int V_ACT  = 480,
    parameter int V_FP   = 10,
    localparam int HAW   = $clog2(H_ACT),
    localparam int VAW   = $clog2(V_ACT)
) (
    input  logic           clk,
    input  logic           rst,
    output logic [HAW-1:0] col,
    output logic [VAW-1:0] row,
    output vid_ctl_t       ctl
);
    localparam int H_TOT   = H_SYNC + H_BP + H_ACT + H_FP;
    localparam int V_TOT   = V_SYNC + V_BP + V_ACT + V_FP;
    localparam int HW      = $clog2(H_TOT);
    localparam int VW      = $clog2(V_TOT);
    localparam int H_START = H_SYNC + H_BP;
    localparam int H_STOP  = H_START + H_ACT;
    localparam int V_START = V_SYNC + V_BP;
    localparam int V_STOP  = V_START + V_ACT;

    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic          h_in;
    logic          v_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (h_cnt == HW'(H_TOT - 1)) begin
            h_cnt <= '0;
            v_cnt <= (v_cnt == VW'(V_TOT - 1)) ? '0 : v_cnt + 1'b1;
        end else begin
            h_cnt <= h_cnt + 1'b1;
        end
    end

    assign h_in = (h_cnt >= HW'(H_START)) && (h_cnt < HW'(H_STOP));
    assign v_in = (v_cnt >= VW'(V_START)) && (v_cnt < VW'(V_STOP));
    assign col  = HAW'(h_cnt - HW'(H_START));
    assign row  = VAW'(v_cnt - VW'(V_START));

    always_comb begin
        ctl.hs_n = (h_cnt >= HW'(H_SYNC));
        ctl.vs_n = (v_cnt >= VW'(V_SYNC));
        ctl.act  = h_in && v_in;
    end

endmodule

// File: rtl/vga_addr_map.sv
module vga_addr_map
    import vga_scan_pkg::*;
#(
    parameter int H_ACT    = 640,
    parameter int V_ACT    = 480,
    parameter int PIX_BITS = 16,
    localparam int HAW     = $clog2(H_ACT),
    localparam int VAW     = $clog2(V_ACT),
    localparam int ADDR_W  = scan_addr_w(H_ACT, V_ACT, PIX_BITS)
) (
    input  logic [HAW-1:0]    col,
    input  logic [VAW-1:0]    row,
    input  logic              act,
    input  logic              xy_mode,
    output logic [ADDR_W-1:0] addr
);
    localparam int FB_W = H_ACT / 2;
    localparam int FB_H = V_ACT / 2;
    localparam int XW   = $clog2(FB_W);
    localparam int YW   = $clog2(FB_H);
    localparam int IW   = $clog2(FB_W * FB_H);
    localparam int SH   = $clog2(PIX_BITS / 8);
    localparam int LW   = ADDR_W - SH;

    logic [XW-1:0] px;
    logic [YW-1:0] py;
    logic [IW-1:0] idx;
    logic [LW-1:0] lin;

    // Dropping the low counter bit repeats each stored pixel over two columns and two lines.
    assign px  = XW'(col >> 1);
    assign py  = YW'(row >> 1);
    assign idx = IW'(py) * IW'(FB_W) + IW'(px);
    assign lin = xy_mode ? LW'({py, px}) : LW'(idx);

    generate
        if (SH == 0) begin : g_byte_pix
            assign addr = act ? lin : '0;
        end else begin : g_wide_pix
            assign addr = act ? {lin, {SH{1'b0}}} : '0;
        end
    endgenerate

endmodule

// File: rtl/vga_pixel_out.sv
module vga_pixel_out
    import vga_scan_pkg::*;
#(
    parameter int PIX_BITS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  vid_ctl_t            ctl_in,
    input  logic [PIX_BITS-1:0] rd_data,
    output logic                hsync_n,
    output logic                vsync_n,
    output logic                blank,
    output logic [29:0]         rgb
);
    vid_ctl_t    ctl_q;
    logic [29:0] colr;

    generate
        if (PIX_BITS == 16) begin : g_565
            assign colr = expand565(rd_data[15:0]);
        end else begin : g_direct
            assign colr = rd_data[29:0];
        end
    endgenerate

    // Stage 1 waits out the memory latency; stage 2 registers every output together.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= CTL_IDLE;
            hsync_n <= 1'b1;
            vsync_n <= 1'b1;
            blank   <= 1'b1;
            rgb     <= '0;
        end else begin
            ctl_q   <= ctl_in;
            hsync_n <= ctl_q.hs_n;
            vsync_n <= ctl_q.vs_n;
            blank   <= !ctl_q.act;
            rgb     <= ctl_q.act ? colr : '0;
        end
    end

endmodule

// File: rtl/vga_scanout.sv
module vga_scanout
    import vga_scan_pkg::*;
#(
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int H_ACT    = 640,
    parameter int H_FP     = 16,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 33,
    parameter int V_ACT    = 480,
    parameter int V_FP     = 10,
    parameter int PIX_BITS = 16,
    localparam int ADDR_W  = scan_addr_w(H_ACT, V_ACT, PIX_BITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                xy_mode,
    output logic [ADDR_W-1:0]   rd_addr,
    input  logic [PIX_BITS-1:0] rd_data,
    output logic                hsync_n,
    output logic                vsync_n,
    output logic                blank,
    output logic [29:0]         rgb
);
    localparam int HAW = $clog2(H_ACT);
    localparam int VAW = $clog2(V_ACT);

    logic [HAW-1:0] col;
    logic [VAW-1:0] row;
    vid_ctl_t       ctl;

    vga_timing #(
        .H_SYNC(H_SYNC), .H_BP(H_BP), .H_ACT(H_ACT), .H_FP(H_FP),
        .V_SYNC(V_SYNC), .V_BP(V_BP), .V_ACT(V_ACT), .V_FP(V_FP)
    ) u_timing (
        .clk (clk),
        .rst (rst),
        .col (col),
        .row (row),
        .ctl (ctl)
    );

    vga_addr_map #(
        .H_ACT(H_ACT), .V_ACT(V_ACT), .PIX_BITS(PIX_BITS)
    ) u_addr (
        .col     (col),
        .row     (row),
        .act     (ctl.act),
        .xy_mode (xy_mode),
        .addr    (rd_addr)
    );

    vga_pixel_out #(
        .PIX_BITS(PIX_BITS)
    ) u_out (
        .clk     (clk),
        .rst     (rst),
        .ctl_in  (ctl),
        .rd_data (rd_data),
        .hsync_n (hsync_n),
        .vsync_n (vsync_n),
        .blank   (blank),
        .rgb     (rgb)
    );

endmodule

// File: rtl/vga_scanout_chk.sv
module vga_scanout_chk #(
    parameter int H_SYNC = 96,
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              hsync_n,
    input logic              vsync_n,
    input logic              blank,
    input logic [29:0]       rgb,
    input logic [ADDR_W-1:0] rd_addr
);
    localparam int RW = $clog2(H_SYNC + 2);

    logic [RW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || hsync_n) begin
            low_run <= '0;
        end else if (low_run != RW'(H_SYNC + 1)) begin
            low_run <= low_run + 1'b1;
        end
    end

    assert_blank_black_R3: assert property (@(posedge clk) disable iff (rst)
        blank |-> (rgb == '0));

    assert_hsync_in_blank_R1: assert property (@(posedge clk) disable iff (rst)
        !hsync_n |-> blank);

    assert_vsync_in_blank_R2: assert property (@(posedge clk) disable iff (rst)
        !vsync_n |-> blank);

    assert_hsync_width_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync_n) |-> (low_run == RW'(H_SYNC)));

    assert_addr_then_video_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_addr != '0) |-> ##2 !blank);

endmodule

bind vga_scanout vga_scanout_chk #(
    .H_SYNC (H_SYNC),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .hsync_n (hsync_n),
    .vsync_n (vsync_n),
    .blank   (blank),
    .rgb     (rgb),
    .rd_addr (rd_addr)
);

// File: tb/vga_scanout_tb.sv
module vga_scanout_tb;

    // Raster tables: row 0 full size, row 1 reduced (sync, back porch, active, front porch).
    localparam int T [2][8] = '{'{96, 48, 640, 16, 2, 33, 480, 10},
                                '{3, 2, 8, 2, 1, 1, 4, 1}};

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst = 1'b1;
    logic        xy_mode = 1'b0;
    logic [17:0] a0;
    logic [15:0] d0;
    logic        hs0, vs0, bl0;
    logic [29:0] c0;
    logic [3:0]  a1;
    logic [15:0] d1;
    logic        hs1, vs1, bl1;
    logic [29:0] c1;

    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;
    int unsigned salt;

    vga_scanout u_dut (
        .clk(clk), .rst(rst), .xy_mode(xy_mode), .rd_addr(a0), .rd_data(d0),
        .hsync_n(hs0), .vsync_n(vs0), .blank(bl0), .rgb(c0)
    );

    vga_scanout #(
        .H_SYNC(3), .H_BP(2), .H_ACT(8), .H_FP(2),
        .V_SYNC(1), .V_BP(1), .V_ACT(4), .V_FP(1)
    ) u_small (
        .clk(clk), .rst(rst), .xy_mode(xy_mode), .rd_addr(a1), .rd_data(d1),
        .hsync_n(hs1), .vsync_n(vs1), .blank(bl1), .rgb(c1)
    );

    function automatic logic [15:0] memf(input int unsigned a);
        int unsigned m;
        m = a * salt + (a >> 3) + 32'h1357;
        return m[15:0];
    endfunction

    // Synchronous memory models: data follows the address by one clock.
    always @(posedge clk) begin
        d0 <= memf(32'(a0));
        d1 <= memf(32'(a1));
    end

    function automatic int htot(input int s);
        return T[s][0] + T[s][1] + T[s][2] + T[s][3];
    endfunction

    function automatic int vtot(input int s);
        return T[s][4] + T[s][5] + T[s][6] + T[s][7];
    endfunction

    function automatic bit ex_act(input int s, input int i);
        int hx;
        int vy;
        hx = (i % htot(s)) - T[s][0] - T[s][1];
        vy = ((i / htot(s)) % vtot(s)) - T[s][4] - T[s][5];
        return (hx >= 0) && (hx < T[s][2]) && (vy >= 0) && (vy < T[s][6]);
    endfunction

    function automatic int unsigned ex_addr(input int s, input int i, input bit mode);
        int px;
        int py;
        int fbw;
        if (!ex_act(s, i)) return 0;
        px  = ((i % htot(s)) - T[s][0] - T[s][1]) / 2;
        py  = (((i / htot(s)) % vtot(s)) - T[s][4] - T[s][5]) / 2;
        fbw = T[s][2] / 2;
        if (mode) return 32'(((py << $clog2(fbw)) | px) * 2);
        return 32'((py * fbw + px) * 2);
    endfunction

    function automatic int unsigned ex_rgb(input logic [15:0] d);
        int unsigned r;
        int unsigned g;
        int unsigned b;
        r = d[15:11];
        g = d[10:5];
        b = d[4:0];
        return ((r * 32 + r) << 20) | ((g * 16 + (g >> 2)) << 10) | (b * 32 + b);
    endfunction

    task automatic chk(input string tag, input int unsigned got, input int unsigned exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic check_reset_state();
        chk("R10 hsync_n", 32'(hs0), 1);
        chk("R10 vsync_n", 32'(vs0), 1);
        chk("R10 blank", 32'(bl0), 1);
        chk("R10 rgb", 32'(c0), 0);
        chk("R10 rd_addr", 32'(a0), 0);
        chk("R10 small blank", 32'(bl1), 1);
        chk("R10 small rd_addr", 32'(a1), 0);
    endtask

    task automatic check_one(input int s, input int k, input int unsigned addr,
                             input logic hs, input logic vs, input logic bl,
                             input logic [29:0] rgb);
        int i;
        string p;
        p = (s == 1) ? "R11 small " : "";
        chk({p, xy_mode ? "R6 R4 R7 rd_addr" : "R5 R4 R7 rd_addr"}, addr, ex_addr(s, k, xy_mode));
        if (k < 2) begin
            chk({p, "R10 hsync_n"}, 32'(hs), 1);
            chk({p, "R10 blank"}, 32'(bl), 1);
            chk({p, "R10 rgb"}, 32'(rgb), 0);
        end else begin
            i = k - 2;
            chk({p, "R1 hsync_n"}, 32'(hs), ((i % htot(s)) >= T[s][0]) ? 1 : 0);
            chk({p, "R2 vsync_n"}, 32'(vs), (((i / htot(s)) % vtot(s)) >= T[s][4]) ? 1 : 0);
            chk({p, "R3 blank"}, 32'(bl), ex_act(s, i) ? 0 : 1);
            chk({p, "R8 R9 rgb"}, 32'(rgb),
                ex_act(s, i) ? ex_rgb(memf(ex_addr(s, i, xy_mode))) : 0);
        end
    endtask

    task automatic run(input bit mode, input int ncyc);
        @(negedge clk);
        rst     = 1'b1;
        xy_mode = mode;
        repeat (2 + ($urandom % 4)) @(posedge clk);
        @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        for (int k = 1; k <= ncyc; k++) begin
            @(posedge clk);
            @(negedge clk);
            check_one(0, k, 32'(a0), hs0, vs0, bl0, c0);
            check_one(1, k, 32'(a1), hs1, vs1, bl1, c1);
        end
    endtask

    initial begin
        salt = $urandom(32'h5eed) | 32'h1;
        run(1'b0, 33000);                 // linear layout into stored row 3
        run(1'b1, 33000);                 // packed layout, rows differ from R5
        run(1'($urandom % 2), 1500);      // reset mid-frame restarts the raster (R10)
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule